// File: doc/BRIEF.md
# Compressed Configuration Stream Decoder

This block reads a serial, bit-packed description of a relocatable hardware task for an island-style programmable fabric. It turns that description into a sequence of typed output beats. Each field arrives most significant bit first, one bit per accepted input handshake. The widths of all fields are fixed at elaboration from four parameters: the routing channel width, the number of logic-block pins, the largest task side, and the size of the logic-block configuration word.

A task opens with a header that holds the task width, the task height and the macro count. One record per macro follows. A record holds the grid X and Y position, the logic-block word and a one-bit coding flag. When the flag is 1, a full raw macro word follows and is forwarded unchanged. When the flag is 0, a route count follows, then that many (input, output) endpoint pairs, which are emitted in stream order. After the last macro the block emits an end beat and then pulses `done`. If the source reports that its stream has ended while a task is still open, the block pulses `err` and goes back to waiting for a new header.

The state machine has 17 states:
- `ST_IDLE` collects the task width.
- `ST_HDR_H` collects the height.
- `ST_HDR_CNT` collects the macro count.
- `ST_POS_X` and `ST_POS_Y` collect the position.
- `ST_LOGIC` collects the logic word.
- `ST_MODE` takes the coding flag.
- `ST_RAW` collects the raw word.
- `ST_RCNT` collects the route count.
- `ST_EP_IN` and `ST_EP_OUT` collect one endpoint pair.
- `ST_EMIT_HDR`, `ST_EMIT_POS`, `ST_EMIT_LOGIC`, `ST_EMIT_RAW`, `ST_EMIT_CONN` and `ST_EMIT_END` each present one beat.

Transitions:
- Each collecting state moves on once its field is complete.
- Each emitting state moves on once its beat is accepted.
- `ST_MODE` branches to `ST_RAW` or `ST_RCNT`.
- `ST_RCNT` with a count of zero, `ST_EMIT_RAW`, and the last `ST_EMIT_CONN` end the macro. The next state is then `ST_POS_X`, or `ST_EMIT_END` when the macro was the last one.
- `ST_EMIT_HDR` goes straight to `ST_EMIT_END` when the macro count is zero.
- `ST_EMIT_END` returns to `ST_IDLE`.
- An abort from any state also returns to `ST_IDLE`.

Top module: `vbs_stream_decoder`

## Requirements
- R1: Header fields.
  - Width and height are each clog2(MAX_DIM) bits (4 by default). The macro count is clog2(MAX_DIM*MAX_DIM) bits (8 by default).
  - The fields come in the order width, height, count.
  - They are emitted as one beat of kind 1, with data {width, height, count} right-aligned.
- R2: Each macro record starts with X then Y, each clog2(MAX_DIM) bits. They are emitted as a beat of kind 2 with data {X, Y} right-aligned.
- R3: The logic-block word of LB_BITS bits (65 by default) follows Y. It is emitted as a beat of kind 3, right-aligned.
- R4: A coding flag bit of 1 after the logic word is followed by RAW_BITS bits (284 by default). These are emitted unchanged as a beat of kind 5. No route count is read for that macro.
- R5: A coding flag of 0 is followed by a route count of clog2(2*CHAN_W) bits (4 by default).
  - That many connections follow. Each is an input endpoint then an output endpoint, each clog2(4*CHAN_W+LOGIC_IO+1) bits (5 by default).
  - Each connection is emitted as a beat of kind 4 with data {input, output}, in stream order.
- R6: A route count of zero produces no connection beats. The next macro record starts immediately.
- R7: After the last macro, or directly after the header when the count is zero, a beat of kind 6 with zero data is emitted. `done` pulses for one cycle, in the cycle after that beat is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `out_kind` and `out_data` hold steady and `in_ready` is low.
- R9: Abort and idle behaviour.
  - `src_end` raised while a task is open and not at its end beat makes `err` pulse for one cycle in the next cycle. The decoder returns to waiting for a header, with no end beat and no `done`, and the next task decodes normally.
  - `src_end` in idle with no header bit taken has no effect.
- R10: After reset, `out_valid`, `done` and `err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input bit is present |
| in_bit | input | 1 | Serial stream bit, MSB of each field first |
| in_ready | output | 1 | Decoder accepts a bit this cycle |
| src_end | input | 1 | Source has no more data for this task |
| out_valid | output | 1 | Output beat is present |
| out_ready | input | 1 | Consumer accepts the beat |
| out_kind | output | 3 | Beat type: 1 header, 2 macro start, 3 logic, 4 connection, 5 raw, 6 end |
| out_data | output | OUT_W (284) | Beat payload, right-aligned |
| done | output | 1 | One-cycle pulse after the end beat is taken |
| err | output | 1 | One-cycle pulse after an early stream end |

## Verification
Each field's beat becomes valid in the first cycle after the clock edge that takes the field's last bit. The bench therefore compares a beat at the negative edge of the cycle in which the beat is handed over, using the `out_ready` value it set for that edge. `done` and `err` are registered one edge after the end-beat handshake and after the `src_end` cycle respectively. Their pulses are counted at the negative edge that follows, and the totals are checked after each scenario. The hold rule is checked by comparing each stalled beat with the beat seen one cycle later, under a repeating ready pattern that drops ready every third cycle.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    typedef enum logic [2:0] {
        BEAT_NONE   = 3'd0,
        BEAT_HEADER = 3'd1,
        BEAT_MACRO  = 3'd2,
        BEAT_LOGIC  = 3'd3,
        BEAT_CONN   = 3'd4,
        BEAT_RAW    = 3'd5,
        BEAT_END    = 3'd6
    } beat_kind_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_HDR_H,
        ST_HDR_CNT,
        ST_EMIT_HDR,
        ST_POS_X,
        ST_POS_Y,
        ST_EMIT_POS,
        ST_LOGIC,
        ST_EMIT_LOGIC,
        ST_MODE,
        ST_RAW,
        ST_EMIT_RAW,
        ST_RCNT,
        ST_EP_IN,
        ST_EP_OUT,
        ST_EMIT_CONN,
        ST_EMIT_END
    } dec_state_e;

endpackage

// File: rtl/vbs_bit_gather.sv
module vbs_bit_gather #(
    parameter int WORD_W = 284,
    parameter int LEN_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              take,
    input  logic              bit_in,
    input  logic [LEN_W-1:0]  len,
    output logic [LEN_W-1:0]  count,
    output logic [WORD_W-1:0] word_next,
    output logic              field_done
);

    logic [WORD_W-1:0] shreg;

    assign word_next  = {shreg[WORD_W-2:0], bit_in};
    assign field_done = take && (count == len - LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            count <= '0;
        end else if (flush || field_done) begin
            shreg <= '0;
            count <= '0;
        end else if (take) begin
            shreg <= word_next;
            count <= count + LEN_W'(1);
        end
    end

    // R1: a field never collects more bits than its declared width
    assert_field_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (count < len));

endmodule

// File: rtl/vbs_countdown.sv
module vbs_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] value
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= '0;
        else if (load)
            value <= load_val;
        else if (dec && value != '0)
            value <= value - W'(1);
    end

endmodule

// File: rtl/vbs_stream_decoder.sv
module vbs_stream_decoder
    import vbs_pkg::*;
#(
    parameter int CHAN_W    = 5,
    parameter int LOGIC_IO  = 7,
    parameter int MAX_DIM   = 16,
    parameter int LB_BITS   = 65,
    parameter int RAW_BITS  = 284,
    localparam int OUT_W    = (RAW_BITS > LB_BITS) ? RAW_BITS : LB_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             in_ready,
    input  logic             src_end,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_kind,
    output logic [OUT_W-1:0] out_data,
    output logic             done,
    output logic             err
);

    localparam int DIM_W = $clog2(MAX_DIM);
    localparam int CNT_W = $clog2(MAX_DIM * MAX_DIM);
    localparam int RC_W  = $clog2(2 * CHAN_W);
    localparam int EP_W  = $clog2(4 * CHAN_W + LOGIC_IO + 1);
    localparam int LEN_W = $clog2(OUT_W + 1);

    dec_state_e state, state_nx;

    logic [LEN_W-1:0] field_len;
    logic [LEN_W-1:0] gcount;
    logic [OUT_W-1:0] word_next;
    logic             collecting, take, fd, abort, hs, macro_end;
    logic [CNT_W-1:0] mac_val;
    logic [RC_W-1:0]  route_val;
    logic [RC_W-1:0]  rc_field;

    logic [DIM_W-1:0]    task_w, task_h, pos_x, pos_y;
    logic [EP_W-1:0]     ep_in, ep_out;
    logic [LB_BITS-1:0]  lb_word;
    logic [RAW_BITS-1:0] raw_word;
    logic                done_q, err_q;
    beat_kind_e          kind_c;

    // field width per collecting state
    always_comb begin
        collecting = 1'b1;
        field_len  = LEN_W'(1);
        unique case (state)
            ST_IDLE, ST_HDR_H, ST_POS_X, ST_POS_Y: field_len = LEN_W'(DIM_W);
            ST_HDR_CNT:                            field_len = LEN_W'(CNT_W);
            ST_LOGIC:                              field_len = LEN_W'(LB_BITS);
            ST_MODE:                               field_len = LEN_W'(1);
            ST_RAW:                                field_len = LEN_W'(RAW_BITS);
            ST_RCNT:                               field_len = LEN_W'(RC_W);
            ST_EP_IN, ST_EP_OUT:                   field_len = LEN_W'(EP_W);
            default:                               collecting = 1'b0;
        endcase
    end

    assign in_ready = collecting && !src_end;
    assign take     = in_valid && in_ready;
    assign abort    = src_end && !(state == ST_IDLE && gcount == '0)
                      && (state != ST_EMIT_END);
    assign hs       = out_valid && out_ready;
    assign rc_field = word_next[RC_W-1:0];

    vbs_bit_gather #(.WORD_W(OUT_W), .LEN_W(LEN_W)) u_gather (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (abort),
        .take       (take),
        .bit_in     (in_bit),
        .len        (field_len),
        .count      (gcount),
        .word_next  (word_next),
        .field_done (fd)
    );

    assign macro_end = !abort && (
                          (state == ST_EMIT_RAW && hs)
                       || (state == ST_RCNT && fd && rc_field == '0)
                       || (state == ST_EMIT_CONN && hs && route_val == RC_W'(1)));

    vbs_countdown #(.W(CNT_W)) u_mac_left (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_HDR_CNT && fd && !abort),
        .load_val (word_next[CNT_W-1:0]),
        .dec      (macro_end),
        .value    (mac_val)
    );

    vbs_countdown #(.W(RC_W)) u_route_left (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_RCNT && fd && !abort),
        .load_val (rc_field),
        .dec      (state == ST_EMIT_CONN && hs && !abort),
        .value    (route_val)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (abort) begin
            state_nx = ST_IDLE;
        end else if (macro_end) begin
            state_nx = (mac_val == CNT_W'(1)) ? ST_EMIT_END : ST_POS_X;
        end else begin
            unique case (state)
                ST_IDLE:       if (fd) state_nx = ST_HDR_H;
                ST_HDR_H:      if (fd) state_nx = ST_HDR_CNT;
                ST_HDR_CNT:    if (fd) state_nx = ST_EMIT_HDR;
                ST_EMIT_HDR:   if (hs) state_nx = (mac_val == '0) ? ST_EMIT_END : ST_POS_X;
                ST_POS_X:      if (fd) state_nx = ST_POS_Y;
                ST_POS_Y:      if (fd) state_nx = ST_EMIT_POS;
                ST_EMIT_POS:   if (hs) state_nx = ST_LOGIC;
                ST_LOGIC:      if (fd) state_nx = ST_EMIT_LOGIC;
                ST_EMIT_LOGIC: if (hs) state_nx = ST_MODE;
                ST_MODE:       if (fd) state_nx = word_next[0] ? ST_RAW : ST_RCNT;
                ST_RAW:        if (fd) state_nx = ST_EMIT_RAW;
                ST_EMIT_RAW:   state_nx = ST_EMIT_RAW;
                ST_RCNT:       if (fd) state_nx = ST_EP_IN;
                ST_EP_IN:      if (fd) state_nx = ST_EP_OUT;
                ST_EP_OUT:     if (fd) state_nx = ST_EMIT_CONN;
                ST_EMIT_CONN:  if (hs) state_nx = ST_EP_IN;
                ST_EMIT_END:   if (hs) state_nx = ST_IDLE;
                default:       state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // field capture and pulse registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            task_w   <= '0;
            task_h   <= '0;
            pos_x    <= '0;
            pos_y    <= '0;
            ep_in    <= '0;
            ep_out   <= '0;
            lb_word  <= '0;
            raw_word <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= (state == ST_EMIT_END) && hs;
            err_q  <= abort;
            if (fd && !abort) begin
                unique case (state)
                    ST_IDLE:   task_w   <= word_next[DIM_W-1:0];
                    ST_HDR_H:  task_h   <= word_next[DIM_W-1:0];
                    ST_POS_X:  pos_x    <= word_next[DIM_W-1:0];
                    ST_POS_Y:  pos_y    <= word_next[DIM_W-1:0];
                    ST_LOGIC:  lb_word  <= word_next[LB_BITS-1:0];
                    ST_RAW:    raw_word <= word_next[RAW_BITS-1:0];
                    ST_EP_IN:  ep_in    <= word_next[EP_W-1:0];
                    ST_EP_OUT: ep_out   <= word_next[EP_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        kind_c   = BEAT_NONE;
        out_data = '0;
        unique case (state)
            ST_EMIT_HDR: begin
                kind_c   = BEAT_HEADER;
                out_data = OUT_W'({task_w, task_h, mac_val});
            end
            ST_EMIT_POS: begin
                kind_c   = BEAT_MACRO;
                out_data = OUT_W'({pos_x, pos_y});
            end
            ST_EMIT_LOGIC: begin
                kind_c   = BEAT_LOGIC;
                out_data = OUT_W'(lb_word);
            end
            ST_EMIT_RAW: begin
                kind_c   = BEAT_RAW;
                out_data = OUT_W'(raw_word);
            end
            ST_EMIT_CONN: begin
                kind_c   = BEAT_CONN;
                out_data = OUT_W'({ep_in, ep_out});
            end
            ST_EMIT_END: kind_c = BEAT_END;
            default: ;
        endcase
    end

    assign out_valid = (kind_c != BEAT_NONE);
    assign out_kind  = kind_c;
    assign done      = done_q;
    assign err       = err_q;

    // R8: a stalled beat is held unchanged
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !src_end) |=>
            (out_valid && $stable(out_kind) && $stable(out_data)));

    // R8: no bit is taken while a beat is pending
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R9: an early stream end raises err and returns to idle
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (err && state == ST_IDLE));

    // R9: err is a single-cycle pulse
    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R7: done only follows an accepted end beat
    assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state == ST_EMIT_END && out_ready));

endmodule

// File: tb/vbs_stream_decoder_bench.sv
module vbs_stream_decoder_bench;

    localparam int DIM_W = 4;
    localparam int CNT_W = 8;
    localparam int RC_W  = 4;
    localparam int EP_W  = 5;
    localparam int LB_W  = 65;
    localparam int RAW_W = 284;
    localparam int OUT_W = 284;

    // macro table: {x[4], y[4], raw flag, route count[4]}
    localparam logic [12:0] MAC_TAB [6] = '{
        {4'd1,  4'd2,  1'b0, 4'd3},
        {4'd3,  4'd0,  1'b1, 4'd0},
        {4'd15, 4'd15, 1'b0, 4'd0},
        {4'd0,  4'd7,  1'b0, 4'd15},
        {4'd9,  4'd4,  1'b1, 4'd0},
        {4'd2,  4'd2,  1'b0, 4'd1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_bit = 1'b0;
    logic             in_ready;
    logic             src_end = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [2:0]       out_kind;
    logic [OUT_W-1:0] out_data;
    logic             done;
    logic             err;

    always #5 clk = ~clk;

    vbs_stream_decoder u_vbs_stream_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_ready  (in_ready),
        .src_end   (src_end),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_kind  (out_kind),
        .out_data  (out_data),
        .done      (done),
        .err       (err)
    );

    bit               q_bits[$];
    logic [2:0]       q_kind[$];
    logic [OUT_W-1:0] q_data[$];
    string            q_tag[$];

    int n_chk = 0, n_bad = 0, n_done = 0, n_err = 0, cyc = 0, rdy_phase = 0;
    bit timed_out = 0, end_req = 0, rdy_mode = 0, stall_prev = 0;
    logic [2:0]       held_kind;
    logic [OUT_W-1:0] held_data;

    task automatic check(input bit ok, input string tag,
                         input logic [OUT_W+2:0] act, input logic [OUT_W+2:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_field(input logic [OUT_W-1:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) q_bits.push_back(v[i]);
    endtask

    task automatic expect_beat(input logic [2:0] k, input logic [OUT_W-1:0] d, input string tag);
        q_kind.push_back(k);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    function automatic logic [OUT_W-1:0] lb_of(input int s);
        logic [OUT_W-1:0] v = '0;
        for (int j = 0; j < LB_W; j++) v[j] = (((j + s) % 3) == 0) ^ (j > 60);
        return v;
    endfunction

    function automatic logic [OUT_W-1:0] raw_of(input int s);
        logic [OUT_W-1:0] v = '0;
        for (int j = 0; j < RAW_W; j++) v[j] = (((j * s + j / 7) % 4) == 1);
        return v;
    endfunction

    function automatic logic [OUT_W-1:0] hdr_val(input int w, input int h, input int c);
        return (OUT_W'(w) << (DIM_W + CNT_W)) | (OUT_W'(h) << CNT_W) | OUT_W'(c);
    endfunction

    function automatic logic [OUT_W-1:0] pair_val(input int a, input int b, input int sh);
        return (OUT_W'(a) << sh) | OUT_W'(b);
    endfunction

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > 150000 && !timed_out) begin
            timed_out = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
        end
        out_ready = rdy_mode ? ((rdy_phase % 3) != 2) : 1'b1;
        rdy_phase++;
        src_end = end_req;
        if (q_bits.size() > 0) begin
            in_valid = 1'b1;
            in_bit   = q_bits[0];
        end else begin
            in_valid = 1'b0;
            in_bit   = 1'b0;
        end
        #1;
        if (err) n_err++;
        if (done) n_done++;
        if (stall_prev)
            check(out_valid && out_kind == held_kind && out_data == held_data && !in_ready,
                  "R8 stalled beat held", {out_kind, out_data}, {held_kind, held_data});
        if (out_valid && out_ready) begin
            if (q_kind.size() == 0) begin
                check(0, "unexpected beat", {out_kind, out_data}, '0);
            end else begin
                logic [2:0]       k = q_kind.pop_front();
                logic [OUT_W-1:0] d = q_data.pop_front();
                string            t = q_tag.pop_front();
                check(out_kind == k && out_data == d, t, {out_kind, out_data}, {k, d});
            end
        end
        stall_prev = out_valid && !out_ready;
        held_kind  = out_kind;
        held_data  = out_data;
        if (in_valid && in_ready) void'(q_bits.pop_front());
    endtask

    task automatic drain();
        while ((q_bits.size() > 0 || q_kind.size() > 0) && !timed_out) step();
        repeat (3) step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        // R10: reset state
        check(!out_valid && in_ready && !done && !err, "R10 reset state",
              {2'b0, out_valid, in_ready, done, err, {(OUT_W-2){1'b0}}},
              {2'b0, 1'b0, 1'b1, 1'b0, 1'b0, {(OUT_W-2){1'b0}}});

        // table-driven task with backpressure (R1..R8)
        rdy_mode = 1;
        push_field(OUT_W'(15), DIM_W);
        push_field(OUT_W'(15), DIM_W);
        push_field(OUT_W'(6), CNT_W);
        expect_beat(3'd1, hdr_val(15, 15, 6), "R1 header beat");
        for (int k = 0; k < 6; k++) begin
            logic [12:0] e = MAC_TAB[k];
            int x = int'(e[12:9]);
            int y = int'(e[8:5]);
            int nr = int'(e[3:0]);
            bool_prev_zero: begin end
            push_field(OUT_W'(x), DIM_W);
            push_field(OUT_W'(y), DIM_W);
            // R6: a macro after a zero-route macro must start directly
            expect_beat(3'd2, pair_val(x, y, DIM_W),
                        (k == 3) ? "R6 macro after zero routes" : "R2 macro start beat");
            push_field(lb_of(k + 1), LB_W);
            expect_beat(3'd3, lb_of(k + 1), "R3 logic beat");
            push_field(OUT_W'(e[4]), 1);
            if (e[4]) begin
                push_field(raw_of(k + 1), RAW_W);
                expect_beat(3'd5, raw_of(k + 1), "R4 raw pass-through");
            end else begin
                push_field(OUT_W'(nr), RC_W);
                for (int i = 0; i < nr; i++) begin
                    int a = (k * 3 + i) % 28;
                    int b = (k * 5 + 2 * i + 1) % 28;
                    push_field(OUT_W'(a), EP_W);
                    push_field(OUT_W'(b), EP_W);
                    expect_beat(3'd4, pair_val(a, b, EP_W), "R5 connection in order");
                end
            end
        end
        expect_beat(3'd6, '0, "R7 end beat");
        drain();
        check(n_done == 1 && n_err == 0, "R7 done pulse after table task",
              (OUT_W+3)'(n_done), (OUT_W+3)'(1));

        // zero macro count: header then end (R7)
        rdy_mode = 0;
        push_field(OUT_W'(1), DIM_W);
        push_field(OUT_W'(1), DIM_W);
        push_field(OUT_W'(0), CNT_W);
        expect_beat(3'd1, hdr_val(1, 1, 0), "R1 header zero count");
        expect_beat(3'd6, '0, "R7 end right after header");
        drain();
        check(n_done == 2, "R7 done after zero-macro task", (OUT_W+3)'(n_done), (OUT_W+3)'(2));

        // early stream end inside a field (R9)
        push_field(OUT_W'(3), DIM_W);
        push_field(OUT_W'(3), DIM_W);
        push_field(OUT_W'(2), CNT_W);
        push_field(OUT_W'(1), DIM_W);
        push_field(OUT_W'(2), 2);
        expect_beat(3'd1, hdr_val(3, 3, 2), "R1 header before abort");
        drain();
        end_req = 1;
        step();
        end_req = 0;
        repeat (3) step();
        check(n_err == 1, "R9 err after early end", (OUT_W+3)'(n_err), (OUT_W+3)'(1));
        check(n_done == 2, "R9 no done after abort", (OUT_W+3)'(n_done), (OUT_W+3)'(2));

        // src_end in idle is ignored (R9)
        end_req = 1;
        step();
        end_req = 0;
        repeat (3) step();
        check(n_err == 1, "R9 idle src_end ignored", (OUT_W+3)'(n_err), (OUT_W+3)'(1));

        // recovery task after abort (R9, R5)
        rdy_mode = 1;
        push_field(OUT_W'(2), DIM_W);
        push_field(OUT_W'(2), DIM_W);
        push_field(OUT_W'(1), CNT_W);
        expect_beat(3'd1, hdr_val(2, 2, 1), "R9 header after recovery");
        push_field(OUT_W'(1), DIM_W);
        push_field(OUT_W'(0), DIM_W);
        expect_beat(3'd2, pair_val(1, 0, DIM_W), "R2 macro after recovery");
        push_field(lb_of(9), LB_W);
        expect_beat(3'd3, lb_of(9), "R3 logic after recovery");
        push_field(OUT_W'(0), 1);
        push_field(OUT_W'(2), RC_W);
        push_field(OUT_W'(27), EP_W);
        push_field(OUT_W'(0), EP_W);
        expect_beat(3'd4, pair_val(27, 0, EP_W), "R5 first connection");
        push_field(OUT_W'(4), EP_W);
        push_field(OUT_W'(31), EP_W);
        expect_beat(3'd4, pair_val(4, 31, EP_W), "R5 second connection");
        expect_beat(3'd6, '0, "R7 end after recovery");
        drain();
        check(n_done == 3 && n_err == 1, "R9 recovery task completes",
              (OUT_W+3)'(n_done), (OUT_W+3)'(3));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule